// File: doc/BRIEF.md
# Configurable External I/O Strobe Decoder

This block watches processor I/O requests, decides whether the requested address belongs to one external peripheral, and, if it does, produces a timed strobe for that peripheral. Every accepted request opens an I/O cycle that is three clocks long. For a match, the strobe is driven during the later clocks of that cycle, and a match flag stays high for the whole cycle.

The match test uses a programmable base address and a bit mask. A small control register selects how the match is made and how the strobe is driven:
- the address width used for the match, either the low byte only or the full 16 bits;
- whether the strobe is inverted;
- whether read strobes are trimmed by one clock;
- which of two buses carries the strobe, an alternate I/O bus or the memory bus.

Out of reset the register is cleared, so only the low byte is compared and the strobes are active low. Each cycle takes a private copy of the register and of the alternate-bus enable when it starts. A register write made while a cycle is running therefore applies from the next cycle on.

Top module: `ioStrbTop`

## Requirements
- R1: After reset the control register is zero, both strobes sit at 1 (inactive for active-low), the match flag is 0, and matching uses only the low 8 address bits.
- R2: With control bit 3 (wide) clear, address bits 15:8 never affect the match: a match requires address bit i to equal base bit i for every i in 7:0 whose mask bit is 1.
- R3: With control bit 3 set, the match compares all 16 address bits against the base, wherever the mask bit is 1.
- R4: A mask bit of 0 makes that address bit a don't-care.
- R5: A request (read or write high) seen on a clock edge while no cycle is running starts a cycle that occupies the next three clocks. The match flag is high for exactly those three clocks when the captured address matched, and is low otherwise.
- R6: For a matching cycle, the strobe is active during clocks 2 and 3 of the cycle. This holds for writes, and for reads when shortening is off.
- R7: With control bit 1 (short read) set, a read strobe is active in clock 3 only. A write strobe keeps its two-clock width.
- R8: With control bit 0 (invert) set, the active level is 1 and the inactive level is 0 on both buses, including while idle.
- R9: A matching strobe goes to the alternate bus when control bit 2 (route) is set and the alternate-bus enable is high. Otherwise it goes to the memory bus. The bus that is not selected stays at its inactive level for the whole cycle.
- R10: Requests that arrive while a cycle is running are ignored. A read request held high starts a new cycle on the first idle edge. When read and write are requested together, the cycle is a read.
- R11: A control register write, or a change of the alternate-bus enable, during a cycle does not alter that cycle's strobes. The new value applies from the following idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 16 | I/O address of the request |
| rdReq | input | 1 | Read request |
| wrReq | input | 1 | Write request |
| cfgBase | input | 16 | Base address to match |
| cfgMask | input | 16 | Compare mask, 1 = bit compared |
| cfgWe | input | 1 | Control register write enable |
| cfgWdata | input | 4 | Control data: bit3 wide, bit2 route, bit1 short read, bit0 invert |
| altBusEn | input | 1 | Alternate I/O bus enabled |
| altStrobe | output | 1 | Strobe on the alternate I/O bus |
| memStrobe | output | 1 | Strobe on the memory bus |
| hit | output | 1 | Match flag for the current cycle |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:
- Addresses that differ only in the high byte, tried in both width modes. A decoder that leaks the high byte into narrow mode misses an access it should take, and a wide mode that ignores the high byte claims a foreign address.
- A read with shortening on, next to a write with shortening on. A strobe that starts one clock early or late, or a write that gets trimmed as well, shows up as a mismatch in clock 2.
- Routing to the alternate bus while that bus is disabled. A design without the fallback drives no strobe at all, or drives both buses.
- A mid-cycle write to the invert bit, and a request held high across a whole cycle. A design that does not snapshot its configuration at cycle start flips polarity in the middle of a strobe, and one that does not ignore requests while busy restarts the cycle.

// File: rtl/ioStrbPkg.sv
package ioStrbPkg;

  // Control handed from the cycle sequencer to the datapath
  typedef struct packed {
    logic capture;    // request accepted on this edge
    logic busy;       // an I/O cycle occupies the current clock
    logic strbNorm;   // clock lies in the normal strobe window
    logic strbShort;  // clock lies in the trimmed read window
  } ctrlStrbT;

  // Control register fields, MSB first, matching the write data bits
  typedef struct packed {
    logic wide;      // bit 3: full-width address compare
    logic routeAlt;  // bit 2: prefer the alternate bus
    logic shortRd;   // bit 1: trim read strobes by one clock
    logic invert;    // bit 0: active-high strobes
  } cfgT;

endpackage

// File: rtl/ioStrbCfgReg.sv
module ioStrbCfgReg
  import ioStrbPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cfgWe,
  input  cfgT  cfgWdata,
  output cfgT  cfgQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgWdata;
  end

endmodule

// File: rtl/ioStrbCtrl.sv
module ioStrbCtrl
  import ioStrbPkg::*;
#(
  parameter int CYC_LEN = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rdReq,
  input  logic     wrReq,
  output ctrlStrbT ctl
);

  localparam int CNT_W = $clog2(CYC_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_CLK = CNT_W'(CYC_LEN);
  localparam logic [CNT_W-1:0] NORM_START = CNT_W'(CYC_LEN - 1);
  localparam logic [CNT_W-1:0] FIRST_CLK = CNT_W'(1);

  logic [CNT_W-1:0] clkNum;  // 0 = idle, otherwise position within the cycle
  logic busy;
  logic accept;

  assign busy = (clkNum != '0);
  assign accept = !busy && (rdReq || wrReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkNum <= '0;
    end else if (accept) begin
      clkNum <= FIRST_CLK;
    end else if (busy) begin
      clkNum <= (clkNum == LAST_CLK) ? '0 : clkNum + FIRST_CLK;
    end
  end

  always_comb begin
    ctl.capture = accept;
    ctl.busy = busy;
    ctl.strbNorm = busy && (clkNum >= NORM_START);
    ctl.strbShort = busy && (clkNum == LAST_CLK);
  end

endmodule

// File: rtl/ioStrbDpath.sv
module ioStrbDpath
  import ioStrbPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrbT          ctl,
  input  cfgT               cfgQ,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgMask,
  input  logic              altBusEn,
  output logic              altStrobe,
  output logic              memStrobe,
  output logic              hit,
  output logic              effInv,
  output logic              effAltEn
);

  localparam logic [ADDR_W-1:0] NARROW_MASK =
    {{(ADDR_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [ADDR_W-1:0] widthMask;
  logic addrMatch;
  logic hitQ;
  logic isRdQ;
  logic altEnQ;
  cfgT  snapQ;
  logic active;
  logic toAlt;

  assign widthMask = cfgQ.wide ? '1 : NARROW_MASK;
  assign addrMatch = (((ioAddr ^ cfgBase) & cfgMask & widthMask) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ <= 1'b0;
      isRdQ <= 1'b0;
      altEnQ <= 1'b0;
      snapQ <= '0;
    end else if (ctl.capture) begin
      hitQ <= addrMatch;
      isRdQ <= rdReq;
      altEnQ <= altBusEn;
      snapQ <= cfgQ;
    end
  end

  assign hit = hitQ && ctl.busy;
  assign effInv = ctl.busy ? snapQ.invert : cfgQ.invert;
  assign effAltEn = ctl.busy ? altEnQ : altBusEn;
  assign active = hit && ((isRdQ && snapQ.shortRd) ? ctl.strbShort : ctl.strbNorm);
  assign toAlt = snapQ.routeAlt && altEnQ;

  // Active level equals the invert bit; inactive is its complement
  assign altStrobe = (active && toAlt) ? effInv : !effInv;
  assign memStrobe = (active && !toAlt) ? effInv : !effInv;

endmodule

// File: rtl/ioStrbTop.sv
module ioStrbTop
  import ioStrbPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NARROW_W = 8,
  parameter int CYC_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgMask,
  input  logic              cfgWe,
  input  logic [3:0]        cfgWdata,
  input  logic              altBusEn,
  output logic              altStrobe,
  output logic              memStrobe,
  output logic              hit
);

  ctrlStrbT ctl;
  cfgT cfgQ;
  logic effInv;
  logic effAltEn;

  ioStrbCfgReg i_cfgReg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgT'(cfgWdata)), .cfgQ(cfgQ)
  );

  ioStrbCtrl #(.CYC_LEN(CYC_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .ctl(ctl)
  );

  ioStrbDpath #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgQ(cfgQ), .ioAddr(ioAddr), .rdReq(rdReq),
    .cfgBase(cfgBase), .cfgMask(cfgMask), .altBusEn(altBusEn),
    .altStrobe(altStrobe), .memStrobe(memStrobe), .hit(hit),
    .effInv(effInv), .effAltEn(effAltEn)
  );

endmodule

// File: rtl/ioStrbChk.sv
module ioStrbChk (
  input logic clk,
  input logic rstN,
  input logic altStrobe,
  input logic memStrobe,
  input logic hit,
  input logic effInv,
  input logic effAltEn
);

  logic altAct;
  logic memAct;
  assign altAct = (altStrobe == effInv);
  assign memAct = (memStrobe == effInv);

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(altAct && memAct)); // R9

  AST_STROBE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (altAct || memAct) |-> hit); // R5

  AST_ALT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    altAct |-> effAltEn); // R9

  AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hit) |=> hit); // R5

  AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (hit && $past(hit)) |-> $stable(effInv)); // R11

endmodule

bind ioStrbTop ioStrbChk i_chk (
  .clk(clk), .rstN(rstN), .altStrobe(altStrobe), .memStrobe(memStrobe),
  .hit(hit), .effInv(effInv), .effAltEn(effAltEn)
);

// File: tb/test_ioStrbTop.sv
`timescale 1ns/1ps
module test_ioStrbTop;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic rdReq = 1'b0;
  logic wrReq = 1'b0;
  logic [15:0] cfgBase = '0;
  logic [15:0] cfgMask = '0;
  logic cfgWe = 1'b0;
  logic [3:0] cfgWdata = '0;
  logic altBusEn = 1'b0;
  logic altStrobe, memStrobe, hit;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit finished = 0;
  string curTag = "R1";

  always #2 clk = ~clk;

  ioStrbTop i_ioStrbTop (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .rdReq(rdReq), .wrReq(wrReq),
    .cfgBase(cfgBase), .cfgMask(cfgMask), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .altBusEn(altBusEn), .altStrobe(altStrobe), .memStrobe(memStrobe), .hit(hit)
  );

  // Behavioural reference state
  int mPos = 0;          // 0 idle, 1..3 clock in cycle
  bit rWide = 0, rRoute = 0, rShort = 0, rInv = 0;
  bit sHit = 0, sRd = 0, sRoute = 0, sShort = 0, sInv = 0, sAltEn = 0;

  function automatic bit refMatch(input logic [15:0] a, input logic [15:0] b,
                                  input logic [15:0] m, input bit wide);
    bit ok = 1;
    for (int i = 0; i < 16; i++)
      if ((i < 8 || wide) && m[i] && (a[i] != b[i])) ok = 0;
    return ok;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPos = 0; rWide = 0; rRoute = 0; rShort = 0; rInv = 0;
      sHit = 0; sRd = 0; sRoute = 0; sShort = 0; sInv = 0; sAltEn = 0;
    end else begin
      if (mPos == 0 && (rdReq || wrReq)) begin
        mPos = 1;
        sHit = refMatch(ioAddr, cfgBase, cfgMask, rWide);
        sRd = rdReq; sRoute = rRoute; sShort = rShort; sInv = rInv; sAltEn = altBusEn;
      end else if (mPos != 0) begin
        mPos = (mPos == 3) ? 0 : mPos + 1;
      end
      if (cfgWe) begin
        rWide = cfgWdata[3]; rRoute = cfgWdata[2]; rShort = cfgWdata[1]; rInv = cfgWdata[0];
      end
    end
  end

  task automatic checkNow();
    bit inv, act, alt, eAlt, eMem, eHit;
    inv = (mPos != 0) ? sInv : rInv;
    act = (mPos != 0) && sHit && ((sRd && sShort) ? (mPos == 3) : (mPos >= 2));
    alt = sRoute && sAltEn;
    eAlt = (act && alt) ? inv : !inv;
    eMem = (act && !alt) ? inv : !inv;
    eHit = (mPos != 0) && sHit;
    checks++;
    if (altStrobe !== eAlt || memStrobe !== eMem || hit !== eHit) begin
      errors++;
      $display("FAIL %s t=%0t alt/mem/hit act %b%b%b exp %b%b%b", curTag, $time,
               altStrobe, memStrobe, hit, eAlt, eMem, eHit);
    end
  endtask

  always @(negedge clk) if (started && !finished) checkNow();

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic writeCfg(input logic [3:0] v);
    cfgWe = 1; cfgWdata = v; tick(1); cfgWe = 0;
  endtask

  task automatic access(input bit rd, input bit wr, input logic [15:0] a);
    ioAddr = a; rdReq = rd; wrReq = wr; tick(1);
    rdReq = 0; wrReq = 0; ioAddr = 16'hFFFF; tick(4);
  endtask

  task automatic finishRun();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    started = 1;
    curTag = "R1";
    tick(3);
    rstN = 1;
    tick(2);
    // R1: explicit idle levels after reset
    checks++;
    if (altStrobe !== 1 || memStrobe !== 1 || hit !== 0) begin
      errors++;
      $display("FAIL R1 idle act %b%b%b exp 110", altStrobe, memStrobe, hit);
    end

    cfgBase = 16'h0034; cfgMask = 16'hFFFF;
    curTag = "R2";
    access(1, 0, 16'hAB34);   // high byte ignored: hit
    access(1, 0, 16'h0035);   // low byte differs: miss
    curTag = "R4";
    cfgMask = 16'hFFF0;
    access(0, 1, 16'h003F);   // masked nibble: hit
    access(0, 1, 16'h0044);   // miss
    cfgMask = 16'hFFFF;
    curTag = "R3";
    writeCfg(4'b1000);
    access(1, 0, 16'hAB34);   // miss in wide mode
    access(1, 0, 16'h0034);   // hit
    curTag = "R6";
    access(0, 1, 16'h0034);
    curTag = "R7";
    writeCfg(4'b1010);
    access(1, 0, 16'h0034);
    access(0, 1, 16'h0034);
    curTag = "R8";
    writeCfg(4'b0001);
    tick(2);
    access(1, 0, 16'h1234);
    access(0, 1, 16'h1299);
    curTag = "R9";
    altBusEn = 1;
    writeCfg(4'b0100);
    access(1, 0, 16'h0034);
    altBusEn = 0;
    access(0, 1, 16'h0034);   // fallback to memory bus
    altBusEn = 1;
    writeCfg(4'b0111);
    access(1, 0, 16'h0034);
    access(0, 1, 16'h0034);
    curTag = "R10";
    writeCfg(4'b0010);
    ioAddr = 16'h0034; rdReq = 1;
    tick(9);                  // held request: ignored while busy
    rdReq = 0; tick(4);
    access(1, 1, 16'h0034);   // both: treated as read, trimmed
    curTag = "R11";
    writeCfg(4'b0000);
    ioAddr = 16'h0034; wrReq = 1; tick(1); wrReq = 0;
    cfgWe = 1; cfgWdata = 4'b0101; altBusEn = 0; tick(1); cfgWe = 0;
    tick(4);
    access(0, 1, 16'h0034);
    tick(2);
    finishRun();
  end

endmodule